// File: doc/BRIEF.md
# Multiplexed Signed/Unsigned Decimal Display

This block captures an 8-bit word from a shared data bus and presents it in decimal on four common-cathode seven-segment digits. Three positions carry the ones, tens and hundreds digits, and a fourth position carries a sign. A mode input picks the interpretation. In unsigned mode the word is a plain binary magnitude from 0 to 255. In signed mode the word is read as two's complement from -128 to 127: the digits show the absolute value and the sign position shows a minus bar when the value is negative.

Only one digit is driven at a time. A small place counter moves to the next position on each cycle where the scan tick input is high. Its value is decoded into one-hot digit enables, and the segment pattern for that position goes out on shared segment lines. The tick is expected to come from a slower rate generator elsewhere, so the scan rate is chosen outside this block. The segment lines and the digit enables are both registered, so they change together on the same clock edge.

Top module: `dec_display_top`

## Requirements
- R1: When `load` is high at a rising clock edge, the bus word is captured and is shown from the next output update on. When `load` is low, changes on `bus_in` have no effect on the outputs.
- R2: `rst` is synchronous and active high. While it is applied, `seg` and `dig_en` are all zero. At the first edge after release the outputs show place 0 of the value 0, which is `seg` = 7'h3F with `dig_en` = 4'b0001.
- R3: Outside reset, exactly one bit of `dig_en` is high. Bit i enables place i: 0 is ones, 1 is tens, 2 is hundreds and 3 is the sign.
- R4: The place index advances by one on each edge where `scan_tick` is high and wraps from 3 to 0. It is held when `scan_tick` is low. The new place appears on the outputs at the second edge after the tick is sampled.
- R5: In unsigned mode (`signed_mode` = 0), places 0 to 2 show the ones, tens and hundreds decimal digits of the value, 0 to 255. Leading zeros are shown.
- R6: In unsigned mode the sign place is blank (`seg` = 0).
- R7: In signed mode (`signed_mode` = 1), places 0 to 2 show the decimal digits of the absolute value of the two's-complement word, 0 to 128.
- R8: In signed mode the sign place shows only segment g (`seg` = 7'h40) when bit 7 of the value is set, and is blank otherwise.
- R9: Segments are active high, with `seg[0]` to `seg[6]` driving segments a to g. The digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R10: `seg` and `dig_en` are registered. They reflect the value, the mode and the place index as they were just before the edge that updates them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture `bus_in` on this edge |
| bus_in | input | 8 | Data bus word |
| signed_mode | input | 1 | 1: two's-complement view, 0: unsigned view |
| scan_tick | input | 1 | Advance the place index on this edge |
| seg | output | 7 | Segment lines a..g in bits 0..6, high lights a segment |
| dig_en | output | 4 | One-hot digit enable, bit 0 ones to bit 3 sign |

## Verification
A corrupted value register or a wrong magnitude conversion shows up as a wrong segment pattern at the very next output update on the affected place. The bench checks every place of every word in both modes, so any such error is seen within one scan of four places. A place counter that skips, sticks or fails to wrap shows up two edges after a tick as a `dig_en` bit other than the expected one. A wrong sign decision shows only when the sign place is enabled, and the sweep reaches that place for each of the 256 words in both modes.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_BLANK = 7'h00;
  localparam seg_t SEG_MINUS = 7'h40;

  // bit 0 = segment a ... bit 6 = segment g, high = lit
  function automatic seg_t digit_to_seg(input logic [3:0] d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = SEG_BLANK;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/disp_value_reg.sv
module disp_value_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] value_q
);
  always_ff @(posedge clk) begin
    if (rst)       value_q <= '0;
    else if (load) value_q <= bus_in;
  end
endmodule

// File: rtl/disp_scan_ctrl.sv
module disp_scan_ctrl #(
  parameter int PLACES = 4,
  localparam int SCAN_W = (PLACES > 1) ? $clog2(PLACES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_tick,
  output logic [SCAN_W-1:0] place,
  output logic [PLACES-1:0] place_onehot
);
  localparam logic [SCAN_W-1:0] LAST = SCAN_W'(PLACES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      place <= '0;
    end else if (scan_tick) begin
      if (place == LAST) place <= '0;
      else               place <= place + SCAN_W'(1);
    end
  end

  for (genvar i = 0; i < PLACES; i++) begin : g_dec
    assign place_onehot[i] = (place == SCAN_W'(i));
  end
endmodule

// File: rtl/disp_bin2dec.sv
module disp_bin2dec #(
  parameter int DATA_W = 8,
  parameter int DIGITS = 3,
  localparam int BCD_W = 4 * DIGITS
) (
  input  logic [DATA_W-1:0] value,
  input  logic              signed_mode,
  output logic [BCD_W-1:0]  bcd,
  output logic              negative
);
  logic [DATA_W-1:0] mag;

  always_comb begin
    negative = signed_mode & value[DATA_W-1];
    mag      = negative ? (~value + DATA_W'(1)) : value;
  end

  // shift-and-add-3 conversion, fully unrolled
  always_comb begin
    logic [BCD_W-1:0] acc;
    acc = '0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[4*d +: 4] >= 4'd5) acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
      end
      acc = {acc[BCD_W-2:0], mag[b]};
    end
    bcd = acc;
  end
endmodule

// File: rtl/dec_display_top.sv
module dec_display_top #(
  parameter int DATA_W = 8,
  parameter int DIGITS = 3,
  localparam int PLACES = DIGITS + 1,
  localparam int SCAN_W = $clog2(PLACES),
  localparam int BCD_W  = 4 * DIGITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              signed_mode,
  input  logic              scan_tick,
  output logic [6:0]        seg,
  output logic [PLACES-1:0] dig_en
);
  import disp_pkg::*;

  logic [DATA_W-1:0] value_q;
  logic [SCAN_W-1:0] place;
  logic [PLACES-1:0] place_onehot;
  logic [BCD_W-1:0]  bcd;
  logic              negative;
  seg_t              place_seg [PLACES];

  disp_value_reg #(.DATA_W(DATA_W)) u_value (
    .clk(clk), .rst(rst), .load(load), .bus_in(bus_in), .value_q(value_q)
  );

  disp_scan_ctrl #(.PLACES(PLACES)) u_scan (
    .clk(clk), .rst(rst), .scan_tick(scan_tick),
    .place(place), .place_onehot(place_onehot)
  );

  disp_bin2dec #(.DATA_W(DATA_W), .DIGITS(DIGITS)) u_conv (
    .value(value_q), .signed_mode(signed_mode), .bcd(bcd), .negative(negative)
  );

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    assign place_seg[i] = digit_to_seg(bcd[4*i +: 4]);
  end
  assign place_seg[DIGITS] = negative ? SEG_MINUS : SEG_BLANK;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg    <= SEG_BLANK;
      dig_en <= '0;
    end else begin
      seg    <= place_seg[place];
      dig_en <= place_onehot;
    end
  end
endmodule

// File: rtl/dec_display_checks.sv
module dec_display_checks #(
  parameter int DATA_W = 8,
  parameter int PLACES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [DATA_W-1:0] bus_in,
  input logic              signed_mode,
  input logic              scan_tick,
  input logic [6:0]        seg,
  input logic [PLACES-1:0] dig_en,
  input logic [DATA_W-1:0] value_q
);
  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    load |=> value_q == $past(bus_in));
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(value_q));
  a_r3_one_digit: assert property (@(posedge clk) disable iff (rst)
    run_q |-> $countones(dig_en) == 1);
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    scan_tick |-> ##2 !$stable(dig_en));
  a_r4_still: assert property (@(posedge clk) disable iff (rst)
    !scan_tick |-> ##2 $stable(dig_en));
  a_r6_blank_sign: assert property (@(posedge clk) disable iff (rst)
    !signed_mode |=> (!dig_en[PLACES-1] || seg == 7'h00));
  a_r8_minus: assert property (@(posedge clk) disable iff (rst)
    (signed_mode && value_q[DATA_W-1]) |=> (!dig_en[PLACES-1] || seg == 7'h40));
endmodule

bind dec_display_top dec_display_checks #(.DATA_W(DATA_W), .PLACES(PLACES)) u_checks (
  .clk(clk), .rst(rst), .load(load), .bus_in(bus_in), .signed_mode(signed_mode),
  .scan_tick(scan_tick), .seg(seg), .dig_en(dig_en), .value_q(value_q)
);

// File: tb/dec_display_top_test.sv
`timescale 1ns/1ps
module dec_display_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic       signed_mode = 1'b0;
  logic       scan_tick = 1'b0;
  logic [6:0] seg;
  logic [3:0] dig_en;

  int checks = 0;
  int errors = 0;
  int place = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dec_display_top uut (
    .clk(clk), .rst(rst), .load(load), .bus_in(bus_in),
    .signed_mode(signed_mode), .scan_tick(scan_tick), .seg(seg), .dig_en(dig_en)
  );

  function automatic logic [6:0] exp_digit(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  function automatic logic [6:0] exp_seg(input int v, input bit sm, input int p);
    int mag;
    bit neg;
    neg = sm && (v >= 128);
    mag = neg ? 256 - v : v;
    if (p == 3) return neg ? 7'h40 : 7'h00;
    if (p == 0) return exp_digit(mag % 10);
    if (p == 1) return exp_digit((mag / 10) % 10);
    return exp_digit((mag / 100) % 10);
  endfunction

  task automatic check(input string req, input logic [6:0] es, input logic [3:0] ed);
    checks++;
    if (seg !== es || dig_en !== ed) begin
      errors++;
      $display("FAIL %s: seg=%h dig_en=%b expected seg=%h dig_en=%b", req, seg, dig_en, es, ed);
    end
  endtask

  task automatic tick_step();
    scan_tick = 1'b1;
    @(negedge clk);
    scan_tick = 1'b0;
    @(negedge clk);
    place = (place + 1) % 4;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [6:0] hold_seg;
    logic [3:0] hold_en;
    repeat (3) @(negedge clk);
    check("R2 reset outputs", 7'h00, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R2 first output after reset", 7'h3F, 4'b0001);

    // exhaustive sweep: every word, both views, every place
    for (int v = 0; v < 256; v++) begin
      bus_in = 8'(v);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      bus_in = ~8'(v);
      for (int m = 0; m < 2; m++) begin
        signed_mode = m[0];
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          if (m == 0)
            check(place == 3 ? "R6 unsigned sign blank" : "R5 R9 unsigned digit",
                  exp_seg(v, 1'b0, place), 4'(1 << place));
          else
            check(place == 3 ? "R8 signed sign" : "R7 R9 signed magnitude digit",
                  exp_seg(v, 1'b1, place), 4'(1 << place));
          tick_step();
        end
      end
    end

    // R10 and R1: bus changes without load do not reach the outputs
    bus_in = 8'd128;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    signed_mode = 1'b1;
    @(negedge clk);
    check("R10 R1 -128 ones", exp_seg(128, 1'b1, 0), 4'b0001);
    hold_seg = seg;
    hold_en = dig_en;
    for (int i = 0; i < 4; i++) begin
      bus_in = 8'(i * 37 + 5);
      @(negedge clk);
      check("R1 R4 no load no tick holds", hold_seg, hold_en);
    end

    // R4 latency: tick seen two edges later
    scan_tick = 1'b1;
    @(negedge clk);
    scan_tick = 1'b0;
    check("R4 output unchanged one edge after tick", hold_seg, hold_en);
    @(negedge clk);
    place = 1;
    check("R4 place advanced", exp_seg(128, 1'b1, 1), 4'b0010);

    // R10: mode switch shows after one edge
    signed_mode = 1'b0;
    @(negedge clk);
    check("R10 mode switch", exp_seg(128, 1'b0, 1), 4'b0010);

    // R2: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    check("R2 reset mid-run", 7'h00, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    place = 0;
    check("R2 after mid-run reset", 7'h3F, 4'b0001);
    for (int k = 1; k < 4; k++) begin
      tick_step();
      check("R3 R5 zero value scan", exp_seg(0, 1'b0, place), 4'(1 << place));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule